// File: doc/BRIEF.md
# Four-Bit Function-Select Arithmetic/Logic Unit

A purely combinational arithmetic/logic unit on two small operands, X and Y. A 3-bit function code picks one of six results: sum, either direction of difference, X passed through, bitwise AND, or zero. All arithmetic goes through one shared ripple adder. Operand routing, zeroing and inversion are set by a handful of select lines decoded straight from the bits of the function code. An accumulator-style datapath would feed its accumulator into X, its constant into Y, and register R itself.

Differences use two's complement. The subtrahend is inverted on its way into the adder and the carry-in is raised. The carry-in comes directly from the low bit of the function code. The output multiplexer is steered by the top code bit: sum when it is 0, AND when it is 1. The two reserved codes are forced to a zero result, so the output is always deterministic. Results wrap modulo 2^W, and no carry, overflow or zero indication leaves the block.

Top module: `alu4_core`

## Requirements
- R1: With f = 3'b000, r equals (x + y) mod 2^W.
- R2: With f = 3'b001, r equals (x - y) mod 2^W.
- R3: With f = 3'b010, r equals x, and y has no effect on r.
- R4: With f = 3'b011, r equals (y - x) mod 2^W.
- R5: With f = 3'b100, r equals x & y (bitwise).
- R6: With f = 3'b110, r equals 0 for every x and y.
- R7: The reserved codes f = 3'b101 and f = 3'b111 give r = 0 for every x and y.
- R8: For the same operands, the f = 3'b001 result and the f = 3'b011 result add to 0 mod 2^W.
- R9: r depends only on the present x, y and f; it holds no state, so the output after all inputs are zero is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | W (4) | First operand |
| y | input | W (4) | Second operand |
| f | input | 3 | Function code |
| r | output | W (4) | Result |

## Verification
The adder and the AND path both compute on every cycle, whatever code is selected. A correct result therefore depends on the output select ignoring the path that was not chosen. The bench provokes this by keeping x and y fixed while it steps f across all eight codes on consecutive cycles. Both paths are then busy with different values, and each sample is judged against the bench's own model for that code. The two subtraction directions share one adder with swapped inputs. The bench applies them back to back on the same operands and checks that their results cancel modulo 16.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int unsigned DATA_W = 4;
    localparam int unsigned FUNC_W = 3;

    typedef enum logic [FUNC_W-1:0] {
        FN_ADD  = 3'b000,
        FN_SUB  = 3'b001,
        FN_PASS = 3'b010,
        FN_RSUB = 3'b011,
        FN_AND  = 3'b100,
        FN_RSV5 = 3'b101,
        FN_ZERO = 3'b110,
        FN_RSV7 = 3'b111
    } alu_fn_e;

    typedef struct packed {
        logic swap;      // route y to adder A, x to adder B
        logic kill_b;    // force second operand to zero
        logic inv_b;     // invert second operand
        logic cin;       // adder carry-in
        logic pick_and;  // output the AND path instead of the sum
        logic valid;     // code is not reserved
    } alu_ctl_t;

    function automatic alu_ctl_t decode_fn(input logic [FUNC_W-1:0] code);
        alu_ctl_t c;
        c.swap     = code[1] & code[0];
        c.kill_b   = code[1] & ~code[0];
        c.inv_b    = code[0];
        c.cin      = code[0];
        c.pick_and = code[2];
        c.valid    = ~(code[2] & code[0]);
        return c;
    endfunction

endpackage

// File: rtl/alu4_decode.sv
module alu4_decode
    import alu4_pkg::*;
(
    input  logic [FUNC_W-1:0] f,
    output alu_ctl_t          ctl
);

    always_comb begin
        ctl = decode_fn(f);
    end

    always_comb begin
        // R4: swapping and zeroing never act together
        assert_route_exclusive_R4: assert ($onehot0({ctl.swap, ctl.kill_b}))
            else $error("swap and kill_b both active");
    end

endmodule

// File: rtl/alu4_operand.sv
module alu4_operand
    import alu4_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  alu_ctl_t     ctl,
    output logic [W-1:0] a,
    output logic [W-1:0] b,
    output logic [W-1:0] and_res
);

    logic [W-1:0] b_src;
    logic [W-1:0] b_gated;

    always_comb begin
        a       = ctl.swap ? y : x;
        b_src   = ctl.swap ? x : y;
        b_gated = ctl.kill_b ? '0 : b_src;
        b       = ctl.inv_b ? ~b_gated : b_gated;
        and_res = a & b_gated;
    end

    always_comb begin
        // R2: an inverted operand is always paired with a raised carry-in
        assert_twos_comp_R2: assert (!ctl.inv_b || ctl.cin)
            else $error("inverted operand without carry-in");
    end

endmodule

// File: rtl/alu4_adder.sv
module alu4_adder #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);

    logic [W-1:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = a[i] ^ b[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
    end

endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu4_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0]      x,
    input  logic [W-1:0]      y,
    input  logic [FUNC_W-1:0] f,
    output logic [W-1:0]      r
);

    alu_ctl_t     ctl;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic [W-1:0] and_res;
    logic [W-1:0] sum;

    alu4_decode u_decode (
        .f   (f),
        .ctl (ctl)
    );

    alu4_operand #(.W(W)) u_operand (
        .x       (x),
        .y       (y),
        .ctl     (ctl),
        .a       (op_a),
        .b       (op_b),
        .and_res (and_res)
    );

    alu4_adder #(.W(W)) u_adder (
        .a   (op_a),
        .b   (op_b),
        .cin (ctl.cin),
        .sum (sum)
    );

    always_comb begin
        if (!ctl.valid)        r = '0;
        else if (ctl.pick_and) r = and_res;
        else                   r = sum;
    end

    always_comb begin
        if (f == FN_ADD)
            assert_add_wraps_R1: assert (r == W'(x + y))
                else $error("add result mismatch");
        if (f == FN_PASS)
            assert_pass_x_R3: assert (r == x)
                else $error("pass result mismatch");
        if (f == FN_ZERO)
            assert_clear_R6: assert (r == '0)
                else $error("clear result nonzero");
        if (f == FN_RSV5 || f == FN_RSV7)
            assert_reserved_zero_R7: assert (r == '0)
                else $error("reserved code result nonzero");
    end

endmodule

// File: tb/sim_alu4_core.sv
module sim_alu4_core;

    localparam int unsigned W = 4;
    localparam time HALF = 10ns;   // 50 MHz

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] x = '0;
    logic [W-1:0] y = '0;
    logic [2:0]   f = 3'b000;
    logic [W-1:0] r;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #HALF clk = ~clk;

    alu4_core #(.W(W)) u0 (
        .x (x),
        .y (y),
        .f (f),
        .r (r)
    );

    function automatic logic [W-1:0] model(input logic [2:0] fc,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        case (fc)
            3'b000:  return W'(a + b);
            3'b001:  return W'(a - b);
            3'b010:  return a;
            3'b011:  return W'(b - a);
            3'b100:  return a & b;
            default: return '0;
        endcase
    endfunction

    // Drive at a rising edge, sample at the following falling edge.
    task automatic apply(input logic [2:0] fc, input logic [W-1:0] a,
                         input logic [W-1:0] b);
        @(posedge clk);
        f = fc; x = a; y = b;
        @(negedge clk);
    endtask

    task automatic expect_r(input string tag, input logic [W-1:0] exp);
        checks++;
        if (r !== exp) begin
            errors++;
            $display("FAIL %s f=%b x=%h y=%h actual=%h expected=%h",
                     tag, f, x, y, r, exp);
        end
    endtask

    task automatic sweep(input string tag, input logic [2:0] fc);
        for (int i = 0; i < 256; i++) begin
            apply(fc, W'(i >> 4), W'(i));
            expect_r(tag, model(fc, W'(i >> 4), W'(i)));
        end
    endtask

    task automatic test_idle_R9;
        apply(3'b000, '0, '0);
        expect_r("R9", '0);
    endtask

    task automatic test_pass_ignores_y_R3;
        for (int i = 0; i < 16; i++) begin
            apply(3'b010, 4'hA, W'(i));
            expect_r("R3", 4'hA);
        end
    endtask

    task automatic test_mirror_R8;
        logic [W-1:0] d1;
        for (int i = 0; i < 256; i++) begin
            apply(3'b001, W'(i >> 4), W'(i));
            d1 = r;
            apply(3'b011, W'(i >> 4), W'(i));
            checks++;
            if (W'(d1 + r) !== '0) begin
                errors++;
                $display("FAIL R8 x=%h y=%h actual=%h expected=0",
                         x, y, W'(d1 + r));
            end
        end
    endtask

    task automatic test_code_walk_R5;
        // operands fixed, code stepped every cycle: both paths busy
        for (int fc = 0; fc < 8; fc++) begin
            apply(3'(fc), 4'hD, 4'h6);
            expect_r("R5", model(3'(fc), 4'hD, 4'h6));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        test_idle_R9;
        sweep("R1", 3'b000);
        sweep("R2", 3'b001);
        sweep("R3", 3'b010);
        sweep("R4", 3'b011);
        sweep("R5", 3'b100);
        sweep("R6", 3'b110);
        sweep("R7", 3'b101);
        sweep("R7", 3'b111);
        test_pass_ignores_y_R3;
        test_mirror_R8;
        test_code_walk_R5;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule